// File: doc/BRIEF.md
# Watchdog Reset Pulse Generator

When the watchdog core signals that its countdown has expired, this block drives a reset pulse outward. The pulse lasts a programmed number of timebase ticks. One configuration word sets the pulse length, whether the pulse is active-high or active-low, and whether the output is driven both ways or only pulled in its asserted direction.

The length field takes ordinary masked writes. The two attribute bits are different: they change only when the top byte of a write carries one of four key values. A length update therefore cannot flip the polarity or drive mode by accident. The outputs are a pad level and an output enable, and together they model a push-pull or an open-drain driver.

Internally the pulse is a two-state machine. `ST_IDLE` moves to `ST_DRIVE` on the transition named *fire*, which happens when an expiry arrives while the block is idle. `ST_DRIVE` stays in `ST_DRIVE` on *count*, which is a tick with ticks still remaining, and on *hold*, which is any cycle without a tick. `ST_DRIVE` returns to `ST_IDLE` on *release*, which is a tick when no ticks remain. `ST_IDLE` stays in `ST_IDLE` on *wait*, which is any cycle without an expiry.

Top module: `rpg_top`

## Requirements
- R1: After reset, the configuration word reads 0x0000_00FF, `rst_level` is 1 (active-low, idle) and `rst_oe` is 0 (open-drain, idle).
- R2: A write with `bus_addr` = 0x18 copies `bus_wdata[19:0]` into the length field (bits 19:0). Bits 29:20 are never written and always read 0.
- R3: A write to 0x18 whose top byte is 0xA5 sets bit 31, which selects an active-high pulse. A top byte of 0x5A clears bit 31, which selects an active-low pulse.
- R4: A write to 0x18 whose top byte is 0xA8 sets bit 30, which selects push-pull drive. A top byte of 0x8A clears bit 30, which selects open-drain drive.
- R5: A write to 0x18 with any other top byte leaves bits 31 and 30 unchanged.
- R6: `bus_rdata` shows the whole configuration word while `bus_addr` is 0x18 and reads 0 at any other address. Writes to any other address change nothing.
- R7: An expiry while idle asserts the pulse from the next cycle. The pulse stays asserted for exactly (length + 1) cycles in which `tick` is high, and releases in the cycle after the last of those ticks.
- R8: The length is captured when the pulse starts. A length write during a pulse does not change that pulse's duration.
- R9: An expiry while the pulse is asserted is ignored.
- R10: `rst_level` equals the pulse activity when bit 31 is 1 and its inverse when bit 31 is 0.
- R11: With bit 30 = 1, `rst_oe` is always 1. With bit 30 = 0, `rst_oe` is 1 only while the pulse is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| expire | input | 1 | Expiry trigger from the watchdog core |
| tick | input | 1 | Timebase tick enable |
| rst_level | output | 1 | Reset pulse level |
| rst_oe | output | 1 | Output enable of the reset pad |

## Verification
The bench measures pulse length in ticks under several patterns: a tick every cycle, a sparse tick, length 0 and the reset length of 255. An off-by-one counter would show up as a pulse one tick too long or too short. It fires expiries in the middle of a pulse and rewrites the length in the middle of a pulse. A design that reloads its counter in either case would produce a stretched pulse. Top bytes that are not keys, and writes to a neighbouring offset, are mixed in throughout. A decoder that treats near-miss values as keys, or that matches an incomplete address, would show flipped attribute bits in the readback.

// File: rtl/rpg_pkg.sv
package rpg_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_DRIVE = 1'b1
    } pulse_state_e;

    localparam logic [7:0] KEY_ACT_HIGH = 8'hA5;
    localparam logic [7:0] KEY_ACT_LOW  = 8'h5A;
    localparam logic [7:0] KEY_PUSHPULL = 8'hA8;
    localparam logic [7:0] KEY_OPENDRN  = 8'h8A;
endpackage

// File: rtl/rpg_cfg_reg.sv
module rpg_cfg_reg
    import rpg_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int CNT_W     = 20,
    parameter logic [ADDR_W-1:0] CFG_OFFSET = 'h18,
    parameter int RST_WIDTH = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cfg_q,
    output logic              act_high,
    output logic              push_pull,
    output logic [CNT_W-1:0]  width
);
    localparam int POL_BIT = DATA_W - 1;
    localparam int DRV_BIT = DATA_W - 2;
    localparam logic [DATA_W-1:0] RST_VALUE = DATA_W'(RST_WIDTH);

    logic [DATA_W-1:0] cfg_d;
    logic [7:0]        key;
    logic              hit;

    assign key = wdata[DATA_W-1 -: 8];
    assign hit = wr_en && (addr == CFG_OFFSET);

    always_comb begin
        cfg_d = cfg_q;
        cfg_d[CNT_W-1:0] = wdata[CNT_W-1:0];
        unique case (key)
            KEY_ACT_HIGH: cfg_d[POL_BIT] = 1'b1;
            KEY_ACT_LOW:  cfg_d[POL_BIT] = 1'b0;
            KEY_PUSHPULL: cfg_d[DRV_BIT] = 1'b1;
            KEY_OPENDRN:  cfg_d[DRV_BIT] = 1'b0;
            default:      ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= RST_VALUE;
        end else if (hit) begin
            cfg_q <= cfg_d;
        end
    end

    assign act_high  = cfg_q[POL_BIT];
    assign push_pull = cfg_q[DRV_BIT];
    assign width     = cfg_q[CNT_W-1:0];
endmodule

// File: rtl/rpg_pulse_fsm.sv
module rpg_pulse_fsm
    import rpg_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             expire,
    input  logic             tick,
    input  logic [CNT_W-1:0] width,
    output logic             busy,
    output logic [CNT_W-1:0] remain
);
    pulse_state_e     state_q, state_d;
    logic [CNT_W-1:0] remain_q, remain_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            remain_q <= '0;
        end else begin
            state_q  <= state_d;
            remain_q <= remain_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        remain_d = remain_q;
        unique case (state_q)
            ST_IDLE: begin
                if (expire) begin            // fire
                    state_d  = ST_DRIVE;
                    remain_d = width;
                end                          // else wait
            end
            ST_DRIVE: begin
                if (tick) begin
                    if (remain_q == '0) begin
                        state_d = ST_IDLE;   // release
                    end else begin
                        remain_d = remain_q - CNT_W'(1); // count
                    end
                end                          // else hold
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign busy   = (state_q == ST_DRIVE);
    assign remain = remain_q;
endmodule

// File: rtl/rpg_out_drive.sv
module rpg_out_drive (
    input  logic busy,
    input  logic act_high,
    input  logic push_pull,
    output logic level,
    output logic oe
);
    always_comb begin
        level = act_high ? busy : ~busy;
        oe    = push_pull | busy;
    end
endmodule

// File: rtl/rpg_top.sv
module rpg_top #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int CNT_W     = 20,
    parameter logic [ADDR_W-1:0] CFG_OFFSET = 'h18,
    parameter int RST_WIDTH = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              expire,
    input  logic              tick,
    output logic              rst_level,
    output logic              rst_oe
);
    logic [DATA_W-1:0] cfg_q;
    logic              act_high;
    logic              push_pull;
    logic [CNT_W-1:0]  width;
    logic              busy;
    logic [CNT_W-1:0]  remain;

    rpg_cfg_reg #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
        .CFG_OFFSET(CFG_OFFSET), .RST_WIDTH(RST_WIDTH)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .cfg_q(cfg_q), .act_high(act_high),
        .push_pull(push_pull), .width(width)
    );

    rpg_pulse_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .expire(expire), .tick(tick),
        .width(width), .busy(busy), .remain(remain)
    );

    rpg_out_drive u_drv (
        .busy(busy), .act_high(act_high), .push_pull(push_pull),
        .level(rst_level), .oe(rst_oe)
    );

    assign bus_rdata = (bus_addr == CFG_OFFSET) ? cfg_q : '0;
endmodule

// File: rtl/rpg_checks.sv
module rpg_checks
    import rpg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 20,
    parameter logic [ADDR_W-1:0] CFG_OFFSET = 'h18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              expire,
    input logic              tick,
    input logic              rst_oe,
    input logic [DATA_W-1:0] cfg_q,
    input logic              push_pull,
    input logic              busy,
    input logic [CNT_W-1:0]  remain
);
    logic       hit;
    logic [7:0] key;
    assign hit = bus_wr && (bus_addr == CFG_OFFSET);
    assign key = bus_wdata[DATA_W-1 -: 8];

    assert_width_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (cfg_q[CNT_W-1:0] == $past(bus_wdata[CNT_W-1:0])));
    assert_pol_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && key == KEY_ACT_HIGH) |=> cfg_q[DATA_W-1]);
    assert_pol_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && key == KEY_ACT_LOW) |=> !cfg_q[DATA_W-1]);
    assert_drv_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && key == KEY_PUSHPULL) |=> cfg_q[DATA_W-2]);
    assert_drv_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && key == KEY_OPENDRN) |=> !cfg_q[DATA_W-2]);
    assert_attr_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && key != KEY_ACT_HIGH && key != KEY_ACT_LOW &&
         key != KEY_PUSHPULL && key != KEY_OPENDRN)
        |=> $stable(cfg_q[DATA_W-1:DATA_W-2]));
    assert_other_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(cfg_q));
    assert_fire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && expire) |=> busy);
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> (busy && $stable(remain)));
    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tick && remain == '0) |=> !busy);
    assert_no_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && expire && tick && remain != '0)
        |=> (busy && remain == $past(remain) - CNT_W'(1)));
    assert_pp_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        push_pull |-> rst_oe);
endmodule

bind rpg_top rpg_checks #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CFG_OFFSET(CFG_OFFSET)
) u_checks (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .expire(expire), .tick(tick), .rst_oe(rst_oe),
    .cfg_q(cfg_q), .push_pull(push_pull), .busy(busy), .remain(remain)
);

// File: tb/rpg_top_tb.sv
module rpg_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h18;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        expire = 1'b0;
    logic        tick = 1'b0;
    logic        rst_level;
    logic        rst_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_cfg;
    logic        m_busy;
    logic [19:0] m_cnt;

    always #4 clk = ~clk;

    rpg_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .expire(expire),
        .tick(tick), .rst_level(rst_level), .rst_oe(rst_oe)
    );

    function automatic logic [31:0] next_cfg(input logic [31:0] c, input logic [31:0] d);
        logic [31:0] n = c;
        n[19:0] = d[19:0];
        if (d[31:24] == 8'hA5) n[31] = 1'b1;
        if (d[31:24] == 8'h5A) n[31] = 1'b0;
        if (d[31:24] == 8'hA8) n[30] = 1'b1;
        if (d[31:24] == 8'h8A) n[30] = 1'b0;
        return n;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock with the given inputs; model updated; outputs compared after the edge
    task automatic cycle(input bit wr, input logic [7:0] a, input logic [31:0] d,
                         input bit ex, input bit tk);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; expire = ex; tick = tk;
        @(posedge clk);
        if (!m_busy && ex) begin
            m_busy = 1'b1; m_cnt = m_cfg[19:0];
        end else if (m_busy && tk) begin
            if (m_cnt == 0) m_busy = 1'b0;
            else m_cnt = m_cnt - 1;
        end
        if (wr && a == 8'h18) m_cfg = next_cfg(m_cfg, d);
        #1;
        chk(bus_rdata == ((a == 8'h18) ? m_cfg : 32'h0), "R6 readback", bus_rdata,
            (a == 8'h18) ? m_cfg : 32'h0);
        chk(rst_level == (m_cfg[31] ? m_busy : ~m_busy), "R10 level", 32'(rst_level),
            32'(m_cfg[31] ? m_busy : ~m_busy));
        chk(rst_oe == (m_cfg[30] | m_busy), "R11 enable", 32'(rst_oe), 32'(m_cfg[30] | m_busy));
    endtask

    // fires one pulse and counts the ticks applied while it is asserted
    task automatic pulse(input int tick_every, input bit retrig, input bit midwr,
                         output int ticks);
        ticks = 0;
        cycle(1'b0, 8'h18, 32'h0, 1'b1, 1'b0);
        for (int i = 0; i < 5000; i++) begin
            bit tk = (i % tick_every) == 0;
            if (rst_level != m_cfg[31]) break;
            if (tk) ticks++;
            cycle(midwr && i == 1, 8'h18, 32'h0000_0014, retrig, tk);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int t;
        int seed;
        seed = $urandom(32'h5EED);
        m_cfg = 32'h0000_00FF; m_busy = 1'b0; m_cnt = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(bus_rdata == 32'hFF, "R1 reset word", bus_rdata, 32'hFF);
        chk(rst_level == 1'b1, "R1 idle level", 32'(rst_level), 1);
        chk(rst_oe == 1'b0, "R1 idle enable", 32'(rst_oe), 0);

        // R7 reset length 255, tick every cycle -> 256 ticks
        pulse(1, 1'b0, 1'b0, t);
        chk(t == 256, "R7 default length", t, 256);

        // R2 R3 active-high, length 3, sparse ticks -> 4 ticks
        cycle(1'b1, 8'h18, 32'hA5F0_0003, 1'b0, 1'b0);
        chk(bus_rdata == 32'h8000_0003, "R2 R3 write", bus_rdata, 32'h8000_0003);
        pulse(3, 1'b0, 1'b0, t);
        chk(t == 4, "R7 sparse tick", t, 4);

        // length 0 -> one tick
        cycle(1'b1, 8'h18, 32'h0000_0000, 1'b0, 1'b0);
        pulse(1, 1'b0, 1'b0, t);
        chk(t == 1, "R7 zero length", t, 1);

        // R9 retrigger during pulse ignored
        cycle(1'b1, 8'h18, 32'h5A00_0005, 1'b0, 1'b0);
        pulse(1, 1'b1, 1'b0, t);
        chk(t == 6, "R9 retrigger", t, 6);

        // R8 length rewrite mid-pulse does not stretch it
        cycle(1'b1, 8'h18, 32'h0000_0004, 1'b0, 1'b0);
        pulse(1, 1'b0, 1'b1, t);
        chk(t == 5, "R8 captured length", t, 5);
        chk(bus_rdata == 32'h0000_0014, "R8 new length stored", bus_rdata, 32'h14);

        // R4 push-pull then open-drain
        cycle(1'b1, 8'h18, 32'hA800_0002, 1'b0, 1'b0);
        chk(rst_oe == 1'b1, "R4 R11 push-pull idle", 32'(rst_oe), 1);
        cycle(1'b1, 8'h18, 32'h8A00_0002, 1'b0, 1'b0);
        chk(rst_oe == 1'b0, "R4 R11 open-drain idle", 32'(rst_oe), 0);

        // R5 non-key top bytes keep attributes
        cycle(1'b1, 8'h18, 32'hA5A8_0001, 1'b0, 1'b0);
        cycle(1'b1, 8'h18, 32'hA400_0007, 1'b0, 1'b0);
        chk(bus_rdata == 32'h8000_0007, "R5 near-miss key", bus_rdata, 32'h8000_0007);
        cycle(1'b1, 8'h18, 32'h5B00_0007, 1'b0, 1'b0);
        chk(bus_rdata[31] == 1'b1, "R5 keep polarity", 32'(bus_rdata[31]), 1);

        // R6 other offset ignored and reads zero
        cycle(1'b1, 8'h1C, 32'h5A00_0001, 1'b0, 1'b0);
        chk(bus_rdata == 32'h0, "R6 other read", bus_rdata, 0);
        cycle(1'b0, 8'h18, 32'h0, 1'b0, 1'b0);
        chk(bus_rdata == 32'h8000_0007, "R6 write ignored", bus_rdata, 32'h8000_0007);

        // constrained random mix
        for (int n = 0; n < 3000; n++) begin
            int r = $urandom_range(0, 99);
            logic [31:0] d = $urandom;
            logic [7:0] a;
            int k = $urandom_range(0, 4);
            d[19:0] = 20'($urandom_range(0, 6));
            d[31:24] = (k == 0) ? 8'hA5 : (k == 1) ? 8'h5A : (k == 2) ? 8'hA8 :
                       (k == 3) ? 8'h8A : d[31:24];
            a = ($urandom_range(0, 3) == 0) ? 8'h1C : 8'h18;
            cycle(r < 8, a, d, r >= 8 && r < 16, $urandom_range(0, 1) == 1);
        end

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule